// File: doc/BRIEF.md
# Single-Byte Serial Port Register Front End

This block is the processor-facing register window of a minimal serial port. A 32-bit bus reaches three word registers: one holding the last received character, one reporting status, and one through which software sends a character. The bit-level serializer, baud timing and line drivers live elsewhere. Toward them the block offers two byte streams: an outgoing pulse stream carrying each transmitted character, and an incoming valid/ready stream feeding a single holding register.

The incoming stream is back-pressured instead of overrun. `rx_ready` is high exactly while the holding register is empty. A character is taken on a cycle where `rx_valid` and `rx_ready` are both high. The sender must then hold its next character until software reads the data register, which empties the holder. The outgoing stream has no ready input, because the line side is assumed to absorb one character per write. The status bit for transmit room is therefore constant.

Bus reads return data combinationally in the cycle of the access. Side effects take place at the clock edge that ends that cycle.

Top module: `byte_port_regs`

## Requirements
- R1: After reset, `rx_ready` is 1, `tx_valid` is 0, a status read returns 0x0000_0002 and a read of the receive data register returns 0.
- R2: A cycle with `rx_valid` and `rx_ready` both high stores `rx_data`, and `rx_ready` is 0 in the next cycle.
- R3: `rx_ready` equals the inverse of the receive-full flag. While it is 0, offered characters are not taken and the held character is unchanged.
- R4: A legal read at byte offset 0x00 returns the held character in bits 7:0 with zeros above, and clears the receive-full flag at the end of that cycle.
- R5: A legal read at byte offset 0x04 returns the status word with bit 0 as receive-full, bit 1 as transmit-room (always 1) and zeros above. It has no side effect.
- R6: A legal write at byte offset 0x08 makes `tx_valid` high in the next cycle only, with `tx_data` equal to bits 7:0 of the written word. Without such a write, `tx_valid` is 0.
- R7: Writes at offset 0x04 change no flag and no held data.
- R8: Offsets 0x0C through 0x1F, writes at 0x00, and reads at 0x08 read as zero and have no effect.
- R9: An access whose byte enables are not all ones is ignored: it reads as zero, has no side effect and sends nothing.
- R10: When a receive data read and a character acceptance fall in one cycle, the read returns the previous contents and clears first. After the edge, the new character is held and the receive-full flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address within the window |
| bus_be | input | DATA_W/8 (4) | Byte enables; only all-ones is legal |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming character offered |
| rx_ready | output | 1 | Holding register empty |
| rx_data | input | CHAR_W (8) | Incoming character |
| tx_valid | output | 1 | One-cycle pulse: outgoing character present |
| tx_data | output | CHAR_W (8) | Outgoing character |

## Verification
A bus read of the receive data register and a character acceptance on the incoming stream can fall in the same cycle. This is possible only when the holder is already empty, because otherwise `rx_ready` blocks acceptance. The bench provokes the case with a directed cycle that reads offset 0x00 while offering a character. It also lets random traffic do the same repeatedly. The bench judges the case by requiring the read to return the stale byte, `rx_ready` to fall after the edge, and a later read to return the new byte with the status flag set.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;
  // byte offsets of the mapped registers
  localparam int OFF_RXD  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_TXD  = 'h08;
  // status bit positions
  localparam int STAT_RXF = 0;
  localparam int STAT_TXR = 1;

  typedef struct packed {
    logic rd_rxd;
    logic rd_stat;
    logic wr_txd;
  } access_t;
endpackage

// File: rtl/byte_port_decode.sv
module byte_port_decode
  import byte_port_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int BE_W         = 4,
  parameter int WINDOW_BYTES = 24
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output access_t           acc
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WINDOW_BYTES);
  localparam logic [IDX_W-1:0]  IDX_RXD   = IDX_W'(OFF_RXD  >> 2);
  localparam logic [IDX_W-1:0]  IDX_STAT  = IDX_W'(OFF_STAT >> 2);
  localparam logic [IDX_W-1:0]  IDX_TXD   = IDX_W'(OFF_TXD  >> 2);

  logic             legal;
  logic [IDX_W-1:0] idx;

  assign idx   = addr[ADDR_W-1:2];
  assign legal = sel && (&be) && (addr < WIN_LIMIT);

  always_comb begin
    acc         = '0;
    acc.rd_rxd  = legal && !wr && (idx == IDX_RXD);
    acc.rd_stat = legal && !wr && (idx == IDX_STAT);
    acc.wr_txd  = legal &&  wr && (idx == IDX_TXD);
  end
endmodule

// File: rtl/byte_port_rx_hold.sv
module byte_port_rx_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              full,
  output logic [CHAR_W-1:0] held
);
  logic take;

  assign in_ready = !full;
  assign take     = in_valid && in_ready;

  // a drain in the same cycle as a take is applied first, then the take wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (take) begin
      full <= 1'b1;
      held <= in_data;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_port_tx_drive.sv
module byte_port_tx_drive #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CHAR_W-1:0] char_in,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= char_in;
    end
  end
endmodule

// File: rtl/byte_port_regs.sv
module byte_port_regs
  import byte_port_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 32,
  parameter int CHAR_W       = 8,
  parameter int WINDOW_BYTES = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [CHAR_W-1:0]   rx_data,
  output logic                tx_valid,
  output logic [CHAR_W-1:0]   tx_data
);
  localparam int BE_W = DATA_W / 8;

  access_t           acc;
  logic              rx_full;
  logic [CHAR_W-1:0] rx_held;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

  byte_port_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .WINDOW_BYTES(WINDOW_BYTES)
  ) u_decode (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .be(bus_be), .acc(acc)
  );

  byte_port_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .drain(acc.rd_rxd),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .full(rx_full), .held(rx_held)
  );

  byte_port_tx_drive #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fire(acc.wr_txd),
    .char_in(bus_wdata[CHAR_W-1:0]),
    .out_valid(tx_valid), .out_data(tx_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.rd_rxd) bus_rdata[CHAR_W-1:0] = rx_held;
    if (acc.rd_stat) begin
      bus_rdata[STAT_RXF] = rx_full;
      bus_rdata[STAT_TXR] = 1'b1;
    end
  end
endmodule

// File: rtl/byte_port_checker.sv
module byte_port_checker
  import byte_port_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 32,
  parameter int CHAR_W       = 8,
  parameter int WINDOW_BYTES = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic [CHAR_W-1:0]   rx_data,
  input logic                tx_valid,
  input logic [CHAR_W-1:0]   tx_data
);
  localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WINDOW_BYTES);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFF_RXD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFF_TXD);

  logic ok, rd_rxd, rd_stat, wr_stat, wr_txd, take;
  logic unused_chk;

  assign unused_chk = ^rx_data;
  assign ok      = bus_sel && (&bus_be) && (bus_addr < WIN_LIMIT);
  assign rd_rxd  = ok && !bus_wr && (bus_addr[ADDR_W-1:2] == A_RXD[ADDR_W-1:2]);
  assign rd_stat = ok && !bus_wr && (bus_addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2]);
  assign wr_stat = ok &&  bus_wr && (bus_addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2]);
  assign wr_txd  = ok &&  bus_wr && (bus_addr[ADDR_W-1:2] == A_TXD[ADDR_W-1:2]);
  assign take    = rx_valid && rx_ready;

  assert_take_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !rx_ready);

  assert_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rd_rxd) |=> !rx_ready);

  assert_read_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !take) |=> rx_ready);

  assert_status_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[STAT_TXR] && (bus_rdata[STAT_RXF] == !rx_ready)
                 && (bus_rdata[DATA_W-1:2] == '0)));

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> (tx_valid && (tx_data == $past(bus_wdata[CHAR_W-1:0]))));

  assert_tx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_txd |=> !tx_valid);

  assert_status_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !rx_valid) |=> $stable(rx_ready));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !rd_rxd && !rd_stat) |-> (bus_rdata == '0));
endmodule

bind byte_port_regs byte_port_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .WINDOW_BYTES(WINDOW_BYTES)
) u_checker (.*);

// File: tb/test_byte_port_regs.sv
`timescale 1ns/1ps
module test_byte_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;

  int checks = 0, errors = 0;
  bit m_full = 1'b0;
  logic [7:0] m_byte = '0;
  bit exp_txv = 1'b0;
  logic [7:0] exp_txd = '0;

  always #2.5 clk = ~clk;

  byte_port_regs i_byte_port_regs (.*);

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(input bit s, input logic [4:0] a, input logic [3:0] b);
    return s && (b == 4'hF) && (a < 5'd24);
  endfunction

  function automatic logic [31:0] model_rd(input bit s, input bit w,
                                           input logic [4:0] a, input logic [3:0] b);
    if (!legal(s, a, b) || w) return 32'h0;
    if (a[4:2] == 3'd0) return {24'h0, m_byte};
    if (a[4:2] == 3'd1) return {30'h0, 1'b1, m_full};
    return 32'h0;
  endfunction

  function automatic string rd_tag(input bit s, input bit w,
                                   input logic [4:0] a, input logic [3:0] b);
    if (s && b != 4'hF) return "R9";
    if (legal(s, a, b) && !w && a[4:2] == 3'd0) return "R4";
    if (legal(s, a, b) && !w && a[4:2] == 3'd1) return "R5";
    return "R8";
  endfunction

  task automatic step(input bit s, input bit w, input logic [4:0] a,
                      input logic [3:0] b, input logic [31:0] wd,
                      input bit rv, input logic [7:0] rd, input string tag);
    bit take, drain;
    logic [31:0] exp;
    string t;
    @(negedge clk);
    chk(tx_valid == exp_txv, "R6", "tx_valid", 32'(tx_valid), 32'(exp_txv));
    if (exp_txv) chk(tx_data == exp_txd, "R6", "tx_data", 32'(tx_data), 32'(exp_txd));
    bus_sel = s; bus_wr = w; bus_addr = a; bus_be = b; bus_wdata = wd;
    rx_valid = rv; rx_data = rd;
    #1;
    exp = model_rd(s, w, a, b);
    t = (tag != "") ? tag : rd_tag(s, w, a, b);
    chk(bus_rdata == exp, t, "rdata", bus_rdata, exp);
    chk(rx_ready == !m_full, (tag != "") ? tag : "R3", "rx_ready",
        32'(rx_ready), 32'(!m_full));
    take  = rv && !m_full;
    drain = legal(s, a, b) && !w && a[4:2] == 3'd0;
    @(posedge clk);
    if (take) begin m_full = 1'b1; m_byte = rd; end
    else if (drain) m_full = 1'b0;
    exp_txv = legal(s, a, b) && w && a[4:2] == 3'd2;
    if (exp_txv) exp_txd = wd[7:0];
  endtask

  task automatic idle();
    step(0, 0, 5'd0, 4'h0, 32'h0, 0, 8'h0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(1, 0, 5'h04, 4'hF, 0, 0, 0, "R1");
    step(1, 0, 5'h00, 4'hF, 0, 0, 0, "R1");
    // R2 accept then R3 back-pressure
    step(0, 0, 0, 0, 0, 1, 8'h3C, "R2");
    step(0, 0, 0, 0, 0, 1, 8'h77, "R2");
    step(1, 0, 5'h04, 4'hF, 0, 1, 8'h55, "R3");
    // R7 status write while full
    step(1, 1, 5'h04, 4'hF, 32'hFFFF_FFFF, 0, 0, "R7");
    step(1, 0, 5'h04, 4'hF, 0, 0, 0, "R7");
    // R9 partial read of data keeps byte held
    step(1, 0, 5'h00, 4'h1, 0, 0, 0, "R9");
    step(1, 0, 5'h04, 4'hF, 0, 0, 0, "R9");
    // R4 read drains; held byte is 0x3C
    step(1, 0, 5'h00, 4'hF, 0, 0, 0, "R4");
    step(1, 0, 5'h04, 4'hF, 0, 0, 0, "R4");
    // R10 read plus accept in one cycle
    step(1, 0, 5'h00, 4'hF, 0, 1, 8'hA5, "R10");
    step(1, 0, 5'h04, 4'hF, 0, 0, 0, "R10");
    step(1, 0, 5'h00, 4'hF, 0, 0, 0, "R10");
    // R6 transmit, R9 partial transmit write, R8 unmapped write/read
    step(1, 1, 5'h08, 4'hF, 32'hDEAD_BE81, 0, 0, "R6");
    step(1, 1, 5'h08, 4'h3, 32'h0000_0042, 0, 0, "R9");
    step(1, 1, 5'h14, 4'hF, 32'h0000_0099, 0, 0, "R8");
    step(1, 0, 5'h08, 4'hF, 0, 0, 0, "R8");
    step(1, 0, 5'h1C, 4'hF, 0, 0, 0, "R8");
    idle();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit s = ($urandom_range(0, 3) != 0);
      bit w = $urandom_range(0, 1);
      logic [4:0] a = 5'($urandom_range(0, 31));
      logic [3:0] b = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      if ($urandom_range(0, 1) == 1) a = {3'($urandom_range(0, 2)), 2'b00};
      step(s, w, a, b, $urandom, $urandom_range(0, 1), 8'($urandom), "");
    end
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule